// File: doc/BRIEF.md
# Cascaded Ninety-Six Source Interrupt Controller

This block gathers interrupt requests from on-chip units and from thirty-two general-purpose input pins and presents them to a processor. It has one interrupt output and a small register bus. The unit requests are sampled into two 32-bit cause banks, low and high. The pin requests are edge-latched into a third cause bank, which has its own mask. That third bank is folded into four summary bits of the high bank, eight pins per summary bit.

Software reads a vector register to find the source to service. The low bank is searched first, then the high bank. The lowest-numbered source that is pending, enabled and allowed by the bank's fixed filter wins. When the winner in the high bank is a summary bit, the search moves on to the masked pin bank. Vectors are numbered 0–31 for the low bank, 32–63 for the high bank and 64–95 for the pins. When no source qualifies, the vector register reads the spurious code 0xFFFF_FFFE, which is -2 in 32 bits. A pin cause is cleared by writing a word to the pin cause register. Each 0 bit in that word clears the matching cause bit, and each 1 bit leaves it as it is.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: The winning low-bank bit n reads back as vector n. The winning high-bank bit n (n < 24) reads back as vector 32+n. The winning pin n reads back as vector 64+n.
- R2: A low-bank bit can produce a vector only if its position is set in 0x3DFF_FFFE. Bits 0, 25, 30 and 31 never produce a vector and never raise the interrupt output.
- R3: A high-bank bit can produce a vector only if its position is set in 0x0F00_0DB7. For example, bit 3 is ignored and bit 4 is allowed.
- R4: High-bank bit 24+k reads as 1 exactly when any pin cause bit in the range 8k to 8k+7 is set, whether or not the pin mask enables it. When the winning high-bank bit is 24 or above, the vector is 64 plus the lowest set bit of (pin cause AND pin mask).
- R5: The low bank takes priority over the high bank. Within a bank, the lowest-numbered qualifying bit wins.
- R6: The vector register reads 0xFFFF_FFFE when nothing qualifies. This includes the case where a summary bit wins but no pin bit is enabled.
- R7: Writing to the pin cause register clears each cause bit whose data bit is 0. Cause bits whose data bit is 1 keep their value.
- R8: After reset, the low mask and the pin mask read 0, the high mask reads 0x0F00_0000, and the vector register reads spurious.
- R9: Mask bit n enables source n of its bank (1 = enabled). Changing a mask never alters a cause bit.
- R10: A pin cause bit is set by a rising edge of its synchronised pin. A pin that is held high does not set its bit again after the bit has been cleared.
- R11: The interrupt output is the OR of all low-bank and high-bank bits that pass both their filter and their mask. It is registered, so it follows the cause and mask state with one cycle of delay.
- R12: Reading any register, including the vector register, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_lo_i | input | 32 | Unit requests for the low bank, level |
| unit_hi_i | input | 32 | Unit requests for the high bank, level (bits 24–27 unused) |
| gp_pin_i | input | 32 | Pin requests, asynchronous, rising edge latched |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select: 0 low cause, 1 high cause, 2 low mask, 3 high mask, 4 pin cause, 5 pin mask, 6 vector |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_sel_i, combinational |
| cpu_irq_o | output | 1 | Interrupt request to the processor |

## Verification
The tests set several bits at once and check that the lowest qualifying bit wins within a bank and that a pending low bit beats any high or pin source. Filtered-out bits are set alone, with every mask open, to show that the filters act independently of the masks. In the pin tests, a summary bit that passes its mask while the pin mask is closed separates the spurious path from an ordinary pin vector. Clearing one pin out of two confirms that only the 0 bits of a write take effect. A pin held high after its bit is cleared shows that latching is by edge and not by level.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BANK_W   = 32;
  localparam int unsigned IDX_W    = $clog2(BANK_W);
  localparam int unsigned SUM_CNT  = 4;
  localparam int unsigned SUM_LSB  = 24;
  localparam int unsigned SUM_GRP  = BANK_W / SUM_CNT;
  localparam int unsigned HI_BASE  = BANK_W;
  localparam int unsigned GP_BASE  = 2 * BANK_W;
  localparam int unsigned VEC_LIM  = 3 * BANK_W;

  localparam logic [BANK_W-1:0] LO_FILTER   = 32'h3dff_fffe;
  localparam logic [BANK_W-1:0] HI_FILTER   = 32'h0f00_0db7;
  localparam logic [BANK_W-1:0] HI_MASK_RST = 32'h0f00_0000;
  localparam logic [BANK_W-1:0] VEC_NONE    = 32'hffff_fffe;

  typedef enum logic [2:0] {
    SEL_LO_CAUSE = 3'd0,
    SEL_HI_CAUSE = 3'd1,
    SEL_LO_MASK  = 3'd2,
    SEL_HI_MASK  = 3'd3,
    SEL_GP_CAUSE = 3'd4,
    SEL_GP_MASK  = 3'd5,
    SEL_VECTOR   = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/irqc_lsb_find.sv
module irqc_lsb_find #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = |req_i;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irqc_gp_bank.sv
module irqc_gp_bank
  import irqc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BANK_W-1:0]  pin_i,
  input  logic               clr_we_i,
  input  logic [BANK_W-1:0]  clr_data_i,
  output logic [BANK_W-1:0]  cause_o,
  output logic [BANK_W-1:0]  rise_o,
  output logic [SUM_CNT-1:0] summary_o
);
  logic [BANK_W-1:0] sync_q [SYNC_STAGES];
  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] cause_q, cause_d;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= '0;
        else        sync_q[g] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= '0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  always_comb begin
    cause_d = cause_q;
    if (clr_we_i) cause_d = cause_q & clr_data_i;
    cause_d = cause_d | rise_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  for (genvar k = 0; k < SUM_CNT; k++) begin : g_sum
    assign summary_o[k] = |cause_q[k*SUM_GRP +: SUM_GRP];
  end
endmodule

// File: rtl/irqc_mask_regs.sv
module irqc_mask_regs
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  reg_sel_e          sel_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] lo_mask_o,
  output logic [BANK_W-1:0] hi_mask_o,
  output logic [BANK_W-1:0] gp_mask_o
);
  logic [BANK_W-1:0] lo_q, hi_q, gp_q;
  logic [BANK_W-1:0] lo_d, hi_d, gp_d;
  logic lo_en, hi_en, gp_en;

  assign lo_en = we_i && (sel_i == SEL_LO_MASK);
  assign hi_en = we_i && (sel_i == SEL_HI_MASK);
  assign gp_en = we_i && (sel_i == SEL_GP_MASK);

  always_comb begin
    lo_d = lo_en ? wdata_i : lo_q;
    hi_d = hi_en ? wdata_i : hi_q;
    gp_d = gp_en ? wdata_i : gp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= HI_MASK_RST;
      gp_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
      gp_q <= gp_d;
    end
  end

  assign lo_mask_o = lo_q;
  assign hi_mask_o = hi_q;
  assign gp_mask_o = gp_q;
endmodule

// File: rtl/irqc_vector_enc.sv
module irqc_vector_enc
  import irqc_pkg::*;
(
  input  logic [BANK_W-1:0] lo_cause_i,
  input  logic [BANK_W-1:0] hi_cause_i,
  input  logic [BANK_W-1:0] gp_cause_i,
  input  logic [BANK_W-1:0] lo_mask_i,
  input  logic [BANK_W-1:0] hi_mask_i,
  input  logic [BANK_W-1:0] gp_mask_i,
  output logic [BANK_W-1:0] vector_o,
  output logic              any_o
);
  logic [BANK_W-1:0] lo_live, hi_live, gp_live;
  logic              lo_f, hi_f, gp_f;
  logic [IDX_W-1:0]  lo_i, hi_i, gp_i;

  assign lo_live = lo_cause_i & LO_FILTER & lo_mask_i;
  assign hi_live = hi_cause_i & HI_FILTER & hi_mask_i;
  assign gp_live = gp_cause_i & gp_mask_i;

  irqc_lsb_find #(.W(BANK_W)) u_lo (.req_i(lo_live), .found_o(lo_f), .idx_o(lo_i));
  irqc_lsb_find #(.W(BANK_W)) u_hi (.req_i(hi_live), .found_o(hi_f), .idx_o(hi_i));
  irqc_lsb_find #(.W(BANK_W)) u_gp (.req_i(gp_live), .found_o(gp_f), .idx_o(gp_i));

  always_comb begin
    vector_o = VEC_NONE;
    if (lo_f) begin
      vector_o = BANK_W'(lo_i);
    end else if (hi_f) begin
      if (32'(hi_i) >= SUM_LSB) begin
        if (gp_f) vector_o = BANK_W'(GP_BASE) + BANK_W'(gp_i);
      end else begin
        vector_o = BANK_W'(HI_BASE) + BANK_W'(hi_i);
      end
    end
  end

  assign any_o = lo_f | hi_f;
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] unit_lo_i,
  input  logic [31:0] unit_hi_i,
  input  logic [31:0] gp_pin_i,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        cpu_irq_o
);
  reg_sel_e          sel;
  logic [BANK_W-1:0] lo_cause_q, lo_cause_d;
  logic [BANK_W-1:0] unit_hi_q, unit_hi_d;
  logic [BANK_W-1:0] hi_cause;
  logic [BANK_W-1:0] gp_cause, gp_rise;
  logic [SUM_CNT-1:0] gp_sum;
  logic [BANK_W-1:0] lo_mask, hi_mask, gp_mask;
  logic [BANK_W-1:0] vector;
  logic              any_live;
  logic              irq_q, irq_d;
  logic              gp_clr_we;

  assign sel       = reg_sel_e'(reg_sel_i);
  assign gp_clr_we = reg_we_i && (sel == SEL_GP_CAUSE);

  always_comb begin
    lo_cause_d = unit_lo_i;
    unit_hi_d  = unit_hi_i;
    irq_d      = any_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cause_q <= '0;
      unit_hi_q  <= '0;
      irq_q      <= 1'b0;
    end else begin
      lo_cause_q <= lo_cause_d;
      unit_hi_q  <= unit_hi_d;
      irq_q      <= irq_d;
    end
  end

  always_comb begin
    hi_cause = unit_hi_q;
    hi_cause[SUM_LSB +: SUM_CNT] = gp_sum;
  end

  irqc_gp_bank #(.SYNC_STAGES(SYNC_STAGES)) u_gp (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (gp_pin_i),
    .clr_we_i  (gp_clr_we),
    .clr_data_i(reg_wdata_i),
    .cause_o   (gp_cause),
    .rise_o    (gp_rise),
    .summary_o (gp_sum)
  );

  irqc_mask_regs u_masks (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (reg_we_i),
    .sel_i    (sel),
    .wdata_i  (reg_wdata_i),
    .lo_mask_o(lo_mask),
    .hi_mask_o(hi_mask),
    .gp_mask_o(gp_mask)
  );

  irqc_vector_enc u_enc (
    .lo_cause_i(lo_cause_q),
    .hi_cause_i(hi_cause),
    .gp_cause_i(gp_cause),
    .lo_mask_i (lo_mask),
    .hi_mask_i (hi_mask),
    .gp_mask_i (gp_mask),
    .vector_o  (vector),
    .any_o     (any_live)
  );

  always_comb begin
    unique case (sel)
      SEL_LO_CAUSE: reg_rdata_o = lo_cause_q;
      SEL_HI_CAUSE: reg_rdata_o = hi_cause;
      SEL_LO_MASK:  reg_rdata_o = lo_mask;
      SEL_HI_MASK:  reg_rdata_o = hi_mask;
      SEL_GP_CAUSE: reg_rdata_o = gp_cause;
      SEL_GP_MASK:  reg_rdata_o = gp_mask;
      SEL_VECTOR:   reg_rdata_o = vector;
      default:      reg_rdata_o = '0;
    endcase
  end

  assign cpu_irq_o = irq_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we_i,
  input logic [2:0]        reg_sel_i,
  input logic              cpu_irq_o,
  input logic [BANK_W-1:0] vector,
  input logic [BANK_W-1:0] lo_cause_q,
  input logic [BANK_W-1:0] gp_cause,
  input logic [BANK_W-1:0] gp_rise
);
  // R1
  vec_low_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vector < BANK_W) |-> lo_cause_q[vector[IDX_W-1:0]]);

  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vector == VEC_NONE) || (vector < VEC_LIM));

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_irq_o |-> ($past(vector) == VEC_NONE));

  // R9
  mask_keeps_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && reg_sel_i == SEL_GP_MASK) |=> (($past(gp_cause) & ~gp_cause) == '0));

  // R10
  no_set_without_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gp_rise == '0) |=> ((gp_cause & ~$past(gp_cause)) == '0));

  // R7
  clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_i && reg_sel_i == SEL_GP_CAUSE) |=> (($past(gp_cause) & ~gp_cause) == '0));
endmodule

bind irq_cascade_ctrl irqc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we_i  (reg_we_i),
  .reg_sel_i (reg_sel_i),
  .cpu_irq_o (cpu_irq_o),
  .vector    (vector),
  .lo_cause_q(lo_cause_q),
  .gp_cause  (gp_cause),
  .gp_rise   (gp_rise)
);

// File: tb/test_irq_cascade_ctrl.sv
module test_irq_cascade_ctrl;
  logic        clk;
  logic        rst_n;
  logic [31:0] unit_lo_i, unit_hi_i, gp_pin_i;
  logic        reg_we_i;
  logic [2:0]  reg_sel_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        cpu_irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  localparam logic [31:0] NONE = 32'hffff_fffe;

  irq_cascade_ctrl i_irq_cascade_ctrl (
    .clk(clk), .rst_n(rst_n), .unit_lo_i(unit_lo_i), .unit_hi_i(unit_hi_i),
    .gp_pin_i(gp_pin_i), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .cpu_irq_o(cpu_irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [31:0] d);
    reg_sel_i = sel;
    #1 d = reg_rdata_o;
  endtask

  task automatic clean();
    unit_lo_i = '0; unit_hi_i = '0; gp_pin_i = '0;
    wr(3'd2, 32'h0); wr(3'd3, 32'h0f00_0000); wr(3'd5, 32'h0);
    cycles(4);
    wr(3'd4, 32'h0);
    cycles(2);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd2, v); check("R8 low mask", v, 32'h0);
    rd(3'd3, v); check("R8 high mask", v, 32'h0f00_0000);
    rd(3'd5, v); check("R8 pin mask", v, 32'h0);
    rd(3'd6, v); check("R8 vector", v, NONE);
    check("R11 irq idle", 32'(cpu_irq_o), 32'h0);
  endtask

  task automatic t_low();
    logic [31:0] v;
    wr(3'd2, 32'hffff_ffff);
    unit_lo_i = 32'h0000_0028;
    cycles(3);
    rd(3'd6, v); check("R1 R5 lowest low bit", v, 32'd3);
    check("R11 irq on low", 32'(cpu_irq_o), 32'h1);
    wr(3'd2, 32'h0000_0020);
    rd(3'd6, v); check("R9 mask selects bit5", v, 32'd5);
    rd(3'd0, v); check("R9 cause kept", v, 32'h0000_0028);
    rd(3'd6, v); rd(3'd6, v); check("R12 vector read again", v, 32'd5);
    clean();
  endtask

  task automatic t_low_filter();
    logic [31:0] v;
    wr(3'd2, 32'hffff_ffff);
    unit_lo_i = 32'hc200_0001;
    cycles(3);
    rd(3'd6, v); check("R2 filtered low bits", v, NONE);
    check("R2 no irq", 32'(cpu_irq_o), 32'h0);
    clean();
  endtask

  task automatic t_high();
    logic [31:0] v;
    wr(3'd3, 32'hffff_ffff);
    unit_hi_i = 32'h0000_0008;
    cycles(3);
    rd(3'd6, v); check("R3 bit3 filtered", v, NONE);
    unit_hi_i = 32'h0000_0018;
    cycles(3);
    rd(3'd6, v); check("R1 R3 high bit4", v, 32'd36);
    wr(3'd2, 32'hffff_ffff);
    unit_lo_i = 32'h0000_0400;
    cycles(3);
    rd(3'd6, v); check("R5 low beats high", v, 32'd10);
    clean();
  endtask

  task automatic t_pins();
    logic [31:0] v;
    wr(3'd5, 32'h0000_0200);
    gp_pin_i = 32'h0000_1200;
    cycles(4);
    rd(3'd1, v); check("R4 summary bit25", v, 32'h0200_0000);
    rd(3'd6, v); check("R1 R4 pin vector", v, 32'd73);
    check("R11 irq on summary", 32'(cpu_irq_o), 32'h1);
    wr(3'd5, 32'h0);
    rd(3'd6, v); check("R6 summary without pin", v, NONE);
    wr(3'd4, ~32'h0000_0200);
    rd(3'd4, v); check("R7 single clear", v, 32'h0000_1000);
    cycles(4);
    rd(3'd4, v); check("R10 held pin no relatch", v, 32'h0000_1000);
    gp_pin_i = 32'h0;
    cycles(3);
    gp_pin_i = 32'h0000_0200;
    cycles(4);
    rd(3'd4, v); check("R10 new edge latches", v, 32'h0000_1200);
    clean();
    rd(3'd4, v); check("R7 all cleared", v, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we_i = 1'b0; reg_sel_i = '0; reg_wdata_i = '0;
    unit_lo_i = '0; unit_hi_i = '0; gp_pin_i = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);
    t_reset();
    t_low();
    t_low_filter();
    t_high();
    t_pins();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule